// File: doc/BRIEF.md
# Password-Locked Fractional Clock Divider

This block takes a set of single-cycle tick inputs, one per candidate clock source, picks one of them, and produces a divided tick. Each output tick follows a programmable number of selected-source ticks. The divide ratio has an integer part and a fractional part. The fractional part is built up in an accumulator, and each accumulator overflow adds one source tick to the following output period. Over many periods the average ratio is therefore the integer part plus the fraction divided by 4096.

Software controls the block through two 32-bit registers: a control word and a divisor word. A write changes either register only when its top byte carries the key value 0x5A. This guards the divider against stray writes. The generator starts when enable is set. It can be stopped in two ways:
- Clearing enable lets the current output period finish first.
- Setting the kill bit stops it at once.

A busy flag shows whether the generator is running. While busy is set, the divisor and the source selection are locked. Software therefore stops the generator and polls busy before it changes either of them.

Top module: `clkdiv_top`

## Requirements
- R1: A register write (wr_en=1) changes nothing unless wr_data[31:24] equals 0x5A. A write with any other top byte leaves both registers and the generator state unchanged.
- R2: Control read-back places the source index at [3:0], enable at [4], kill at [5] and busy at [7]. Bit 6 and bits 31:8 read 0, and a write cannot change busy. Divisor read-back places the fraction at [11:0] and the integer at [23:12]. Bits 31:24 read 0 for both registers. rd_sel=0 selects control and rd_sel=1 selects divisor, combinationally.
- R3: A source index N below NUM_SRC routes src_tick[N] to the divider. For example, index 6 uses src_tick[6]. An index of NUM_SRC or more selects no input, and ticks on inputs that are not selected are never counted.
- R4: When the control register holds enable=1 and kill=0 while the generator is idle, busy_o goes to 1 on the next clock edge, and counting starts from zero.
- R5: With integer part D and fraction 0, clk_en_o pulses for one cycle once every D selected ticks. The pulse is registered and appears in the cycle after the D-th tick. D=0 behaves like D=1.
- R6: Each output pulse adds the fraction to a 12-bit accumulator. An overflow makes the next output period one selected tick longer. For example, integer 3 with fraction 2048 gives periods of 3, 4, 3, 4 ticks after an initial period of 3.
- R7: If kill is 1 in the control register while running, busy_o clears on the next edge with no output pulse. The generator stays stopped while kill remains 1.
- R8: If enable is 0 while running and kill is 0, the generator completes its current period. It emits that period's pulse, and busy_o falls on the same edge.
- R9: While busy_o is 1, a keyed divisor write is ignored, and the source field of a keyed control write is ignored. The enable and kill bits of that control write still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 divisor |
| wr_data | input | 32 | Write word, top byte is the key |
| rd_sel | input | 1 | Read target: 0 control, 1 divisor |
| rd_data | output | 32 | Combinational read-back of the selected register |
| src_tick | input | NUM_SRC | One tick input per candidate source |
| clk_en_o | output | 1 | Divided output tick, one cycle wide |
| busy_o | output | 1 | Generator running |

## Verification
The bench builds the block with its default parameters: eight source inputs and full 12-bit integer and fraction fields. With these values, index 6 is a valid input and index 9 is out of range. A divisor of 100 and a half-step fraction of 2048 are both exercised. The 12-bit fraction field lets the bench drive accumulator overflow patterns over a few hundred cycles. With both sparse random ticks and dense ticks, the stop-while-mid-period and lock-while-busy cases come up within a few thousand cycles.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
// Package: constants and field positions shared by the divider modules.
// Assumes the 32-bit register word layout described in the brief.
package clkdiv_pkg;
    localparam logic [7:0] WR_KEY   = 8'h5A;
    localparam int         KEY_LSB  = 24;
    localparam int         SRC_W    = 4;
    localparam int         EN_BIT   = 4;
    localparam int         KILL_BIT = 5;
    localparam int         BUSY_BIT = 7;

    typedef enum logic {
        SEL_CTL = 1'b0,
        SEL_DIV = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/clkdiv_regs.sv
`timescale 1ns/1ps
// Module: clkdiv_regs
// Holds the control and divisor registers. A write lands only with the
// key byte present; the source field and the whole divisor are frozen
// while the generator reports busy. Assumes INT_W + FRAC_W <= 24.
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int INT_W  = 12,
    parameter int FRAC_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              busy_i,
    output logic [SRC_W-1:0]  src_o,
    output logic              en_o,
    output logic              kill_o,
    output logic [INT_W-1:0]  int_o,
    output logic [FRAC_W-1:0] frac_o
);
    logic key_ok;

    // Key byte comparison for the current write word.
    always_comb key_ok = (wr_data[31:KEY_LSB] == WR_KEY);

    // Register update: keyed writes only, locked fields held while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_o  <= '0;
            en_o   <= 1'b0;
            kill_o <= 1'b0;
            int_o  <= '0;
            frac_o <= '0;
        end else if (wr_en && key_ok) begin
            if (reg_sel_e'(wr_sel) == SEL_CTL) begin
                en_o   <= wr_data[EN_BIT];
                kill_o <= wr_data[KILL_BIT];
                if (!busy_i) src_o <= wr_data[SRC_W-1:0];
            end else if (!busy_i) begin
                frac_o <= wr_data[FRAC_W-1:0];
                int_o  <= wr_data[FRAC_W +: INT_W];
            end
        end
    end

    // R1: an unkeyed write leaves every register untouched.
    a_r1_unkeyed_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31:KEY_LSB] != WR_KEY) |=>
            ($stable(src_o) && $stable(en_o) && $stable(kill_o) &&
             $stable(int_o) && $stable(frac_o)));

    // R9: divisor and source hold while the generator is busy.
    a_r9_locked_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> ($stable(int_o) && $stable(frac_o) && $stable(src_o)));
endmodule

// File: rtl/clkdiv_src_sel.sv
`timescale 1ns/1ps
// Module: clkdiv_src_sel
// Routes the tick of the selected source to the divider. An index with
// no matching input yields no tick. Assumes NUM_SRC <= 2**SEL_W.
module clkdiv_src_sel #(
    parameter int NUM_SRC = 8,
    parameter int SEL_W   = 4
) (
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               tick_o
);
    logic [NUM_SRC-1:0] hit;

    // One match gate per source input.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = src_tick[g] && (int'(sel_i) == g);
    end

    // Combine the gated ticks; at most one gate can be open.
    always_comb tick_o = |hit;
endmodule

// File: rtl/clkdiv_core.sv
`timescale 1ns/1ps
// Module: clkdiv_core
// Counts selected ticks and emits one registered pulse per period. The
// period is the integer part (0 read as 1) plus one tick whenever the
// previous pulse overflowed the fraction accumulator. Kill stops at once;
// a cleared enable stops on the next pulse. Assumes divisor inputs are
// stable while running (the register block enforces this).
module clkdiv_core #(
    parameter int INT_W  = 12,
    parameter int FRAC_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              en_i,
    input  logic              kill_i,
    input  logic [INT_W-1:0]  div_int_i,
    input  logic [FRAC_W-1:0] div_frac_i,
    output logic              busy_o,
    output logic              clk_en_o
);
    localparam int CNT_W = INT_W + 1;

    logic              run;
    logic [CNT_W-1:0]  cnt;
    logic [FRAC_W-1:0] acc;
    logic              extra;
    logic              pulse_q;
    logic [CNT_W-1:0]  base;
    logic [CNT_W-1:0]  period;
    logic [CNT_W-1:0]  cnt_inc;
    logic              last;
    logic [FRAC_W:0]   acc_sum;

    // Period length and end-of-period detection.
    always_comb begin
        base    = (div_int_i == '0) ? CNT_W'(1) : {1'b0, div_int_i};
        period  = base + CNT_W'(extra);
        cnt_inc = cnt + CNT_W'(1);
        last    = (cnt_inc >= period);
        acc_sum = {1'b0, acc} + {1'b0, div_frac_i};
    end

    // Run state, tick counter, fraction accumulator and output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            cnt     <= '0;
            acc     <= '0;
            extra   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (!run) begin
                if (en_i && !kill_i) begin
                    run   <= 1'b1;
                    cnt   <= '0;
                    acc   <= '0;
                    extra <= 1'b0;
                end
            end else if (kill_i) begin
                run <= 1'b0;
                cnt <= '0;
            end else if (tick_i) begin
                if (last) begin
                    pulse_q <= 1'b1;
                    cnt     <= '0;
                    acc     <= acc_sum[FRAC_W-1:0];
                    extra   <= acc_sum[FRAC_W];
                    if (!en_i) run <= 1'b0;
                end else begin
                    cnt <= cnt_inc;
                end
            end
        end
    end

    // Drive outputs from registers.
    always_comb begin
        busy_o   = run;
        clk_en_o = pulse_q;
    end

    // R4: an idle generator with enable and no kill starts on the next edge.
    a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && en_i && !kill_i) |=> run);

    // R7: kill while running stops without a pulse.
    a_r7_kill_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (run && kill_i) |=> (!run && !pulse_q));

    // R8: a stop without kill always coincides with the final pulse.
    a_r8_graceful_stop: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(run) && !$past(kill_i)) |-> pulse_q);

    // R5: every pulse follows a counted tick.
    a_r5_pulse_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> ($past(tick_i) && $past(run)));
endmodule

// File: rtl/clkdiv_top.sv
`timescale 1ns/1ps
// Module: clkdiv_top
// Keyed control/divisor registers, source selection and fractional
// divider. Read-back is combinational; the key byte always reads 0.
module clkdiv_top
    import clkdiv_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int INT_W   = 12,
    parameter int FRAC_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [31:0]        wr_data,
    input  logic               rd_sel,
    output logic [31:0]        rd_data,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic               clk_en_o,
    output logic               busy_o
);
    logic [SRC_W-1:0]  src_q;
    logic              en_q;
    logic              kill_q;
    logic [INT_W-1:0]  int_q;
    logic [FRAC_W-1:0] frac_q;
    logic              sel_tick;
    logic              busy;

    clkdiv_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .busy_i  (busy),
        .src_o   (src_q),
        .en_o    (en_q),
        .kill_o  (kill_q),
        .int_o   (int_q),
        .frac_o  (frac_q)
    );

    clkdiv_src_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SRC_W)) u_sel (
        .src_tick (src_tick),
        .sel_i    (src_q),
        .tick_o   (sel_tick)
    );

    clkdiv_core #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (sel_tick),
        .en_i       (en_q),
        .kill_i     (kill_q),
        .div_int_i  (int_q),
        .div_frac_i (frac_q),
        .busy_o     (busy),
        .clk_en_o   (clk_en_o)
    );

    // Read-back multiplexer; unused positions and the key byte are zero.
    always_comb begin
        rd_data = '0;
        if (reg_sel_e'(rd_sel) == SEL_DIV) begin
            rd_data[FRAC_W-1:0]     = frac_q;
            rd_data[FRAC_W +: INT_W] = int_q;
        end else begin
            rd_data[SRC_W-1:0] = src_q;
            rd_data[EN_BIT]    = en_q;
            rd_data[KILL_BIT]  = kill_q;
            rd_data[BUSY_BIT]  = busy;
        end
    end

    // Busy output.
    always_comb busy_o = busy;
endmodule

// File: tb/clkdiv_top_bench.sv
`timescale 1ns/1ps
module clkdiv_top_bench;
    localparam int NSRC = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic            wr_sel = 1'b0;
    logic [31:0]     wr_data = '0;
    logic            rd_sel = 1'b0;
    logic [31:0]     rd_data;
    logic [NSRC-1:0] src_tick = '0;
    logic            clk_en_o;
    logic            busy_o;

    always #10 clk = ~clk;   // 50 MHz

    clkdiv_top #(.NUM_SRC(NSRC), .INT_W(12), .FRAC_W(12)) u_clkdiv_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .src_tick(src_tick), .clk_en_o(clk_en_o), .busy_o(busy_o)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;
    int pulses[$];

    logic [NSRC-1:0] tick_mask = '0;
    bit              tick_dense = 1;

    // Tick stimulus, changed away from the active edge.
    always @(negedge clk)
        src_tick = tick_dense ? tick_mask : (tick_mask & NSRC'($urandom));

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference state.
    int m_src, m_en, m_kill, m_int, m_frac, m_run, m_cnt, m_acc, m_extra, m_out;

    always @(posedge clk) begin : model
        int tk, per, sum;
        int n_src, n_en, n_kill, n_int, n_frac, n_run, n_cnt, n_acc, n_extra, n_out;
        logic [31:0] exp_rd;
        if (!rst_n) begin
            m_src = 0; m_en = 0; m_kill = 0; m_int = 0; m_frac = 0;
            m_run = 0; m_cnt = 0; m_acc = 0; m_extra = 0; m_out = 0;
        end else begin
            tk = (m_src < NSRC) ? int'(src_tick[m_src]) : 0;
            n_src = m_src; n_en = m_en; n_kill = m_kill; n_int = m_int; n_frac = m_frac;
            n_run = m_run; n_cnt = m_cnt; n_acc = m_acc; n_extra = m_extra; n_out = 0;
            if (m_run == 0) begin
                if (m_en != 0 && m_kill == 0) begin
                    n_run = 1; n_cnt = 0; n_acc = 0; n_extra = 0;
                end
            end else if (m_kill != 0) begin
                n_run = 0; n_cnt = 0;
            end else if (tk != 0) begin
                per = ((m_int == 0) ? 1 : m_int) + m_extra;
                if (m_cnt + 1 >= per) begin
                    n_out = 1; n_cnt = 0;
                    sum = m_acc + m_frac;
                    n_acc = sum % 4096;
                    n_extra = sum / 4096;
                    if (m_en == 0) n_run = 0;
                end else begin
                    n_cnt = m_cnt + 1;
                end
            end
            if (wr_en && wr_data[31:24] == 8'h5A) begin
                if (wr_sel == 1'b0) begin
                    n_en = int'(wr_data[4]);
                    n_kill = int'(wr_data[5]);
                    if (m_run == 0) n_src = int'(wr_data[3:0]);
                end else if (m_run == 0) begin
                    n_int = int'(wr_data[23:12]);
                    n_frac = int'(wr_data[11:0]);
                end
            end
            m_src = n_src; m_en = n_en; m_kill = n_kill; m_int = n_int; m_frac = n_frac;
            m_run = n_run; m_cnt = n_cnt; m_acc = n_acc; m_extra = n_extra; m_out = n_out;
        end
        cyc++;
        #5;
        exp_rd = rd_sel ? 32'((m_int << 12) | m_frac)
                        : 32'(m_src | (m_en << 4) | (m_kill << 5) | (m_run << 7));
        chk(clk_en_o === m_out[0], "R5 output pulse vs model", clk_en_o, m_out);
        chk(busy_o === m_run[0], "R4 busy vs model", busy_o, m_run);
        chk(rd_data === exp_rd, "R2 read-back vs model", rd_data, exp_rd);
        if (clk_en_o === 1'b1) pulses.push_back(cyc);
    end

    function automatic logic [31:0] ctlw(logic [7:0] k, int src, bit en, bit kill);
        return {k, 16'h0, 2'b00, kill, en, 4'(src)};
    endfunction

    function automatic logic [31:0] divw(logic [7:0] k, int i, int f);
        return {k, 12'(i), 12'(f)};
    endfunction

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #7;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        @(negedge clk);
        rd_sel = sel;
        @(posedge clk);
        #7;
        v = rd_data;
    endtask

    initial begin : watchdog
        #(20 * 150000);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd(1'b0, v); chk(v == 32'h0, "R2 control reset value", v, 0);
        rd(1'b1, v); chk(v == 32'h0, "R2 divisor reset value", v, 0);

        // R1: unkeyed divisor writes
        wr(1'b1, divw(8'h00, 5, 0));
        rd(1'b1, v); chk(v == 32'h0, "R1 unkeyed divisor write ignored", v, 0);
        wr(1'b1, divw(8'hA5, 9, 3));
        rd(1'b1, v); chk(v == 32'h0, "R1 wrong key divisor write ignored", v, 0);
        wr(1'b1, divw(8'h5A, 5, 0));
        rd(1'b1, v); chk(v == 32'h0000_5000, "R2 divisor read-back, key byte zero", v, 32'h5000);

        // R1: unkeyed enable does not start
        tick_mask = 8'h04; tick_dense = 1;
        wr(1'b0, ctlw(8'h00, 2, 1, 0));
        settle(3); chk(busy_o == 1'b0, "R1 unkeyed enable ignored", busy_o, 0);

        // R4: keyed enable starts one edge after the register holds it
        wr(1'b0, ctlw(8'h5A, 2, 1, 0));
        chk(busy_o == 1'b0, "R4 busy low before start edge", busy_o, 0);
        settle(1); chk(busy_o == 1'b1, "R4 busy high after start", busy_o, 1);

        // R5: divide by 5 with dense ticks
        pulses.delete();
        settle(30);
        chk(pulses.size() >= 5 && pulses[4] - pulses[3] == 5, "R5 divide by 5 spacing",
            pulses.size() >= 5 ? pulses[4] - pulses[3] : -1, 5);

        // R3: ticks only on unselected inputs
        tick_mask = 8'hFB;
        settle(2); pulses.delete();
        settle(40); chk(pulses.size() == 0, "R3 unselected inputs not counted", pulses.size(), 0);
        tick_mask = 8'h04;

        // R9: locked while busy
        wr(1'b1, divw(8'h5A, 7, 0));
        rd(1'b1, v); chk(v == 32'h0000_5000, "R9 divisor locked while busy", v, 32'h5000);
        wr(1'b0, ctlw(8'h5A, 3, 1, 0));
        rd(1'b0, v); chk(v == 32'h0000_0092, "R9 source locked, enable kept, R2 busy bit", v, 32'h92);

        // R8: graceful stop
        wr(1'b0, ctlw(8'h5A, 2, 0, 0));
        chk(busy_o == 1'b1, "R8 still busy after enable cleared", busy_o, 1);
        for (int i = 0; i < 20 && busy_o; i++) settle(1);
        chk(busy_o == 1'b0, "R8 generator stopped", busy_o, 0);
        chk(clk_en_o == 1'b1, "R8 final pulse with busy fall", clk_en_o, 1);

        // R6 and R3: fractional divide on input 6
        tick_mask = 8'h40;
        wr(1'b1, divw(8'h5A, 3, 2048));
        wr(1'b0, ctlw(8'h5A, 6, 1, 0));
        pulses.delete();
        settle(40);
        chk(pulses.size() >= 5 && pulses[1] - pulses[0] == 3, "R6 first period without carry",
            pulses.size() >= 5 ? pulses[1] - pulses[0] : -1, 3);
        chk(pulses.size() >= 5 && pulses[2] - pulses[1] == 4, "R6 carry lengthens period",
            pulses.size() >= 5 ? pulses[2] - pulses[1] : -1, 4);
        chk(pulses.size() >= 5 && pulses[4] - pulses[0] == 14, "R3 input 6 routed, R6 four periods",
            pulses.size() >= 5 ? pulses[4] - pulses[0] : -1, 14);

        // R7: kill
        wr(1'b0, ctlw(8'h5A, 6, 1, 1));
        chk(busy_o == 1'b1, "R7 busy before kill edge", busy_o, 1);
        settle(1); chk(busy_o == 1'b0, "R7 kill stops at once", busy_o, 0);
        pulses.delete();
        settle(30); chk(pulses.size() == 0, "R7 no pulses while kill held", pulses.size(), 0);

        // R5: integer 0 acts as 1
        wr(1'b1, divw(8'h5A, 0, 0));
        wr(1'b0, ctlw(8'h5A, 6, 1, 0));
        settle(1); chk(busy_o == 1'b1, "R4 restart after kill cleared", busy_o, 1);
        pulses.delete();
        settle(10);
        chk(pulses.size() >= 3 && pulses[2] - pulses[1] == 1, "R5 integer zero divides by one",
            pulses.size() >= 3 ? pulses[2] - pulses[1] : -1, 1);

        // R5: divide by 100
        wr(1'b0, ctlw(8'h5A, 6, 1, 1));
        settle(1);
        wr(1'b1, divw(8'h5A, 100, 0));
        wr(1'b0, ctlw(8'h5A, 6, 1, 0));
        pulses.delete();
        settle(320);
        chk(pulses.size() >= 2 && pulses[1] - pulses[0] == 100, "R5 divide by 100 spacing",
            pulses.size() >= 2 ? pulses[1] - pulses[0] : -1, 100);

        // R3: out-of-range index selects nothing
        wr(1'b0, ctlw(8'h5A, 6, 1, 1));
        settle(1);
        tick_mask = 8'hFF;
        wr(1'b0, ctlw(8'h5A, 9, 1, 0));
        pulses.delete();
        settle(40);
        chk(busy_o == 1'b1, "R3 runs with index 9", busy_o, 1);
        chk(pulses.size() == 0, "R3 index 9 selects no input", pulses.size(), 0);

        // Sparse random ticks on input 1 with a fraction
        wr(1'b0, ctlw(8'h5A, 9, 1, 1));
        settle(1);
        wr(1'b1, divw(8'h5A, 7, 1000));
        tick_mask = 8'h02; tick_dense = 0;
        wr(1'b0, ctlw(8'h5A, 1, 1, 0));
        pulses.delete();
        settle(3000);
        chk(pulses.size() > 0, "R6 random ticks produce pulses", pulses.size(), 1);

        // R1: unkeyed kill while running
        wr(1'b0, ctlw(8'h11, 1, 1, 1));
        settle(2); chk(busy_o == 1'b1, "R1 unkeyed kill ignored", busy_o, 1);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule